// File: doc/BRIEF.md
# Lock-gated split K-counter loop filter

This block is the loop filter and lock supervisor of a low-power all-digital PLL. It turns the phase detector's error pulse and its direction into advance and retard pulses for the digitally controlled oscillator. The filter count is held in two counters. One steps on the rising clock edge and the other on the falling edge, so each clock cycle with an error present adds two steps. When the combined count reaches the modulus K in either direction, the block emits one pulse and both counters restart at zero.

A lock monitor measures how many cycles the error is present in each reference period. After a run of quiet periods it raises the lock flag, and from then on the counters freeze. The modulus register loads only in cycles where the error input is present, so the modulus logic toggles less as the loop settles. A wide error in any period drops the lock in that same cycle, and counting resumes.

All inputs pass through one register stage. The modulus must be at least 3. There is no data stream at this block's edge, so every pin is a plain control or status pin with no handshake.

Top module: `lockgated_kfilter`

## Requirements
- R1: While reset is asserted, and right after it, `advance_o`, `retard_o` and `locked_o` are 0 and both counters hold zero.
- R2: Each cycle in which `ph_err_i` is 1 and the filter is unlocked adds two steps to the combined count: up when `ref_leads_i` is 1, down when it is 0. An input held from cycle 0 with K=6 produces its first advance pulse in cycle 3, one cycle after the cycle in which the count reaches 6.
- R3: When the combined count reaches +K, `advance_o` pulses. When it reaches -K, `retard_o` pulses. In both cases the count restarts at zero.
- R4: Each pulse lasts one cycle for any K of 3 or more, and the two pulses are never high together.
- R5: Cycles with `ph_err_i` at 0 leave the combined count unchanged. Counting picks up from the held value when the error returns.
- R6: A reference period ends with the cycle in which `ref_tick_i` is 1. A period is quiet when its error cycles number at most LOCK_WIN (default 2). `locked_o` rises one cycle after the tick that closes the LOCK_PERIODS-th consecutive quiet period (default 16).
- R7: When the error cycles counted in the current period exceed LOCK_WIN, `locked_o` falls one cycle later and counting resumes in the next error cycle.
- R8: While `locked_o` is 1, no pulse is issued and the combined count is kept, not cleared.
- R9: `modulus_i` is captured only in cycles where `ph_err_i` is 1. A new modulus applied between error bursts governs the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both edges are used inside |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_err_i | input | 1 | Phase error present this cycle |
| ref_leads_i | input | 1 | 1: reference leads (count up); 0: lags (count down) |
| ref_tick_i | input | 1 | Marks the last cycle of a reference period |
| modulus_i | input | KW | Filter modulus K (3 or more) |
| advance_o | output | 1 | One-cycle pulse: oscillator should advance |
| retard_o | output | 1 | One-cycle pulse: oscillator should retard |
| locked_o | output | 1 | Loop declared locked; filter frozen |

## Verification
The bench sweeps K over a range in both directions and across gapped, direction-flipping error patterns. It predicts each pulse count by accumulating two steps per error cycle. A design that let one of the two counters miss an edge would pulse at half the rate, and one that kept the residue after a wrap would drift from the predicted counts. The lock edges are checked to the exact cycle: one period early or late, or a drop deferred to the period tick, shows up as a wrong flag in a named cycle. The frozen count is probed by setting K just above the reconstructed total. A filter that kept counting while locked then pulses during the burst, and one that cleared on lock never pulses, so a single extra error cycle separates the three cases.

// File: rtl/lgkf_pkg.sv
package lgkf_pkg;

  // Control inputs after the capture stage; the field order matches the port order
  typedef struct packed {
    logic err;
    logic lead;
    logic tick;
  } ctl_s;

  // Counter width: room for a signed total of up to +/-(K+1)
  function automatic int unsigned cnt_width(int unsigned kw);
    return kw + 2;
  endfunction

endpackage

// File: rtl/lgkf_capture.sv
module lgkf_capture
  import lgkf_pkg::*;
#(
  parameter int unsigned KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_s          ctl_i,
  input  logic [KW-1:0] mod_i,
  output ctl_s          ctl_q,
  output logic [KW-1:0] k_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      k_q   <= '1;
    end else begin
      ctl_q <= ctl_i;
      // modulus register toggles only while an error is present
      if (ctl_i.err) k_q <= mod_i;
    end
  end

  p_k_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_i.err |=> $stable(k_q));

endmodule

// File: rtl/lgkf_split_counter.sv
module lgkf_split_counter
  import lgkf_pkg::*;
#(
  parameter int unsigned KW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          up_i,
  input  logic [KW-1:0] k_i,
  output logic          adv_o,
  output logic          ret_o
);

  localparam int unsigned CW = cnt_width(KW);

  logic signed [CW-1:0] rise_q, fall_q, step_v, sum_nx, kpos, kneg;
  logic                 wrap_q;

  // +1 when up, -1 when down, 0 when disabled
  assign step_v = en_i ? $signed({{(CW-1){~up_i}}, 1'b1}) : '0;
  assign sum_nx = rise_q + step_v + fall_q;
  assign kpos   = $signed({2'b00, k_i});
  assign kneg   = -kpos;

  // Rising-edge half: decides wraps and drives the pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      wrap_q <= 1'b0;
      adv_o  <= 1'b0;
      ret_o  <= 1'b0;
    end else begin
      adv_o  <= 1'b0;
      ret_o  <= 1'b0;
      wrap_q <= 1'b0;
      if (en_i && (sum_nx >= kpos)) begin
        adv_o  <= 1'b1;
        rise_q <= '0;
        wrap_q <= 1'b1;
      end else if (en_i && (sum_nx <= kneg)) begin
        ret_o  <= 1'b1;
        rise_q <= '0;
        wrap_q <= 1'b1;
      end else begin
        rise_q <= rise_q + step_v;
      end
    end
  end

  // Falling-edge half: restarts after a wrap, then keeps stepping
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      fall_q <= '0;
    else if (wrap_q) fall_q <= step_v;
    else             fall_q <= fall_q + step_v;
  end

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(rise_q));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o || ret_o) |-> (rise_q == '0));

  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adv_o, ret_o}));

  p_single_adv_r4: assert property (@(posedge clk) disable iff (!rst_n || (k_i < KW'(3)))
    adv_o |=> !adv_o);

  p_single_ret_r4: assert property (@(posedge clk) disable iff (!rst_n || (k_i < KW'(3)))
    ret_o |=> !ret_o);

endmodule

// File: rtl/lgkf_lock_mon.sv
module lgkf_lock_mon #(
  parameter int unsigned LOCK_WIN     = 2,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  input  logic tick_i,
  output logic locked_o
);

  localparam int unsigned WW = $clog2(LOCK_WIN + 2);
  localparam int unsigned QW = $clog2(LOCK_PERIODS + 1);

  logic [WW-1:0] width_q, width_nx;
  logic [QW-1:0] quiet_q;
  logic          over;

  // running error width of this period, saturating one past the window
  assign width_nx = (width_q > WW'(LOCK_WIN)) ? width_q : width_q + WW'(err_i);
  assign over     = width_nx > WW'(LOCK_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      quiet_q  <= '0;
      locked_o <= 1'b0;
    end else if (tick_i) begin
      width_q <= '0;
      if (over) begin
        quiet_q  <= '0;
        locked_o <= 1'b0;
      end else begin
        if (quiet_q < QW'(LOCK_PERIODS))       quiet_q  <= quiet_q + 1'b1;
        if (quiet_q >= QW'(LOCK_PERIODS - 1))  locked_o <= 1'b1;
      end
    end else begin
      width_q <= width_nx;
      if (over) begin
        quiet_q  <= '0;
        locked_o <= 1'b0;
      end
    end
  end

  p_drop_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && over) |=> !locked_o);

  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(tick_i));

  p_rise_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> ($past(quiet_q) == QW'(LOCK_PERIODS - 1)));

endmodule

// File: rtl/lockgated_kfilter.sv
module lockgated_kfilter
  import lgkf_pkg::*;
#(
  parameter int unsigned KW           = 8,
  parameter int unsigned LOCK_WIN     = 2,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_err_i,
  input  logic          ref_leads_i,
  input  logic          ref_tick_i,
  input  logic [KW-1:0] modulus_i,
  output logic          advance_o,
  output logic          retard_o,
  output logic          locked_o
);

  ctl_s          ctl_in, ctl_q;
  logic [KW-1:0] k_q;
  logic          count_en;

  assign ctl_in   = {ph_err_i, ref_leads_i, ref_tick_i};
  // the lock flag gates the whole filter
  assign count_en = ctl_q.err & ~locked_o;

  lgkf_capture #(.KW(KW)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_i (ctl_in),
    .mod_i (modulus_i),
    .ctl_q (ctl_q),
    .k_q   (k_q)
  );

  lgkf_split_counter #(.KW(KW)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (count_en),
    .up_i  (ctl_q.lead),
    .k_i   (k_q),
    .adv_o (advance_o),
    .ret_o (retard_o)
  );

  lgkf_lock_mon #(.LOCK_WIN(LOCK_WIN), .LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_i    (ctl_q.err),
    .tick_i   (ctl_q.tick),
    .locked_o (locked_o)
  );

  p_silent_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> !(advance_o || retard_o));

endmodule

// File: tb/tb_lockgated_kfilter.sv
`timescale 1ns/1ps
module tb_lockgated_kfilter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ph_err, ref_leads, ref_tick;
  logic [7:0] modulus;
  logic       advance, retard, locked;

  int checks = 0, errors = 0;
  int tcnt = 0, n_adv = 0, n_ret = 0, viol = 0;
  logic prev_adv = 1'b0, prev_ret = 1'b0;

  always #2 clk = ~clk;

  lockgated_kfilter dut (
    .clk(clk), .rst_n(rst_n), .ph_err_i(ph_err), .ref_leads_i(ref_leads),
    .ref_tick_i(ref_tick), .modulus_i(modulus),
    .advance_o(advance), .retard_o(retard), .locked_o(locked)
  );

  // pulse monitor on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_adv <= 1'b0; prev_ret <= 1'b0;
    end else begin
      if (advance) n_adv++;
      if (retard)  n_ret++;
      if ((advance && retard) || (advance && prev_adv) || (retard && prev_ret)) viol++;
      prev_adv <= advance; prev_ret <= retard;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; the period tick falls on every eighth cycle
  task automatic step(input logic e, input logic d);
    ph_err = e; ref_leads = d; ref_tick = (tcnt % 8 == 7);
    tcnt++;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ph_err = 1'b0; ref_leads = 1'b0; ref_tick = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1; tcnt = 0; n_adv = 0; n_ret = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tot, ea, er;
    modulus = 8'd6;
    rst_n = 1'b0; ph_err = 1'b0; ref_leads = 1'b0; ref_tick = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    // R1 reset state
    chk("R1 advance in reset", int'(advance), 0);
    chk("R1 retard in reset", int'(retard), 0);
    chk("R1 locked in reset", int'(locked), 0);

    // R3 sweep of K, continuous error, both directions
    for (int k = 3; k <= 24; k++) begin
      for (int dd = 0; dd < 2; dd++) begin
        do_reset(); modulus = 8'(k);
        tot = 0; ea = 0; er = 0;
        for (int i = 0; i < 40; i++) begin
          step(1'b1, dd[0]);
          tot += dd[0] ? 2 : -2;
          if (tot >= k) begin ea++; tot = 0; end
          else if (tot <= -k) begin er++; tot = 0; end
        end
        for (int i = 0; i < 4; i++) step(1'b0, dd[0]);
        chk("R3 advance count", n_adv, ea);
        chk("R3 retard count", n_ret, er);
      end
    end

    // R5 gapped error with direction changes
    for (int k = 3; k <= 12; k++) begin
      do_reset(); modulus = 8'(k);
      tot = 0; ea = 0; er = 0;
      for (int i = 0; i < 64; i++) begin
        logic e, d;
        e = (i % 4 != 3);
        d = ((i / 5) % 3 != 2);
        step(e, d);
        if (e) begin
          tot += d ? 2 : -2;
          if (tot >= k) begin ea++; tot = 0; end
          else if (tot <= -k) begin er++; tot = 0; end
        end
      end
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
      chk("R5 advance count gapped", n_adv, ea);
      chk("R5 retard count gapped", n_ret, er);
    end

    // R2 exact pulse cycle, K=6
    do_reset(); modulus = 8'd6;
    step(1'b1, 1'b1); chk("R2 no pulse c0", int'(advance), 0);
    step(1'b1, 1'b1); chk("R2 no pulse c1", int'(advance), 0);
    step(1'b1, 1'b1); chk("R2 no pulse c2", int'(advance), 0);
    step(1'b1, 1'b1); chk("R2 first pulse c3", int'(advance), 1);
    step(1'b1, 1'b1); chk("R2 pulse ends c4", int'(advance), 0);
    step(1'b1, 1'b1); chk("R2 no pulse c5", int'(advance), 0);
    step(1'b1, 1'b1); chk("R2 second pulse c6", int'(advance), 1);

    // R6 lock after 16 quiet periods, R8 freeze, R7 drop
    do_reset(); modulus = 8'd100;
    for (int s = 0; s < 152; s++) begin
      step(s % 8 == 3, 1'b1);
      if (s == 126) chk("R6 not yet locked", int'(locked), 0);
      if (s == 128) chk("R6 locked after 16th tick", int'(locked), 1);
    end
    chk("R8 still locked", int'(locked), 1);
    chk("R8 no pulse before burst", n_adv, 0);
    for (int s = 152; s < 188; s++) begin
      step(1'b1, 1'b1);
      if (s == 154) chk("R7 lock held at width 2", int'(locked), 1);
      if (s == 155) chk("R7 lock dropped at width 3", int'(locked), 0);
    end
    chk("R8 held count below K after burst", n_adv, 0);
    for (int s = 188; s < 194; s++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int s = 195; s < 200; s++) step(1'b0, 1'b1);
    chk("R8 held count reaches K", n_adv, 1);
    chk("R7 unlocked", int'(locked), 0);

    // R1 reset clears lock
    do_reset(); modulus = 8'd100;
    for (int s = 0; s < 136; s++) step(s % 8 == 3, 1'b1);
    chk("R6 relocked", int'(locked), 1);
    rst_n = 1'b0; #1;
    chk("R1 reset drops lock", int'(locked), 0);
    @(posedge clk); #1;

    // R9 modulus taken with the next burst
    do_reset(); modulus = 8'd10;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    chk("R9 one pulse with K=10", n_adv, 1);
    modulus = 8'd4;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    chk("R9 two pulses with K=4", n_adv, 3);

    chk("R4 pulse width and exclusivity", viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule